// File: doc/BRIEF.md
# USB Serial Receive Path

This block recovers packets from a sampled USB differential pair. A separate clock recovery stage presents one sample of the D+/D- pair per bit time, marked by a one-cycle `bit_en`. The block classifies each sample as J, K or single-ended zero (SE0) and turns the NRZI line levels back into data bits. While idle it hunts for the sync field. Once sync is found it strips stuffed bits, packs the remaining bits into bytes and presents each byte to the protocol engine on a parallel bus.

A packet is framed by `rx_active`. The signal rises when the sync field completes and falls when the packet ends, either cleanly or with an error. A clean end is two SE0 bit times followed by a J, and it is signalled with a one-cycle `rx_eop`. A missing stuffed zero, or a malformed SE0 run, is a receive error. The error is signalled with a one-cycle `rx_error`, after which the receiver stays deaf until the line next passes through SE0 and back to J. Bits left over at the end of a packet that do not fill a byte are dropped.

Top module: `usbrx_top`

## Requirements
- R1: The pair `{line_dp,line_dm}` is read as 2'b10 = J, 2'b01 = K, 2'b00 = SE0. A sample decodes to 1 when its level (`line_dp`) equals that of the previous non-SE0 sample, and to 0 when it differs. The previous level is J after reset.
- R2: While idle, the receiver asserts `rx_active` at the clock edge of the final sync bit. The sync field is seven decoded 0 bits followed by one decoded 1. Any other sequence, including a sync field cut short, leaves `rx_active` low.
- R3: Data bits are packed least significant bit first into 8-bit bytes. Each completed byte appears on `rx_data` together with a single-cycle `rx_valid` pulse, on the edge of the byte's last bit.
- R4: After six consecutive decoded 1 bits, the next bit is a stuffed 0 and is removed from the data. The final 1 of the sync field counts toward the six.
- R5: A 1 in a position where a stuffed 0 is required raises `rx_error` for one cycle and drops `rx_active` on the same edge. No byte is delivered from that packet after the error.
- R6: After an error, all line activity, including a valid sync field, is ignored until an SE0 sample is directly followed by a J sample. Hunting for sync then resumes.
- R7: Inside a packet, two SE0 bit times followed by a J end the packet: `rx_eop` pulses for one cycle and `rx_active` falls on that edge. An SE0 run of any other length inside a packet is a receive error, handled as in R5.
- R8: Bits of an incomplete byte at the end of a packet are discarded and never produce `rx_valid`.
- R9: After reset, `rx_active`, `rx_valid`, `rx_error` and `rx_eop` are low.
- R10: State advances only on clock edges where `bit_en` is high. Line activity while `bit_en` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe marking a valid line sample |
| line_dp | input | 1 | Sampled D+ level |
| line_dm | input | 1 | Sampled D- level |
| rx_data | output | 8 | Most recently completed byte |
| rx_valid | output | 1 | Single-cycle pulse when `rx_data` holds a new byte |
| rx_active | output | 1 | High from sync detection to end of packet or error |
| rx_error | output | 1 | Single-cycle receive error pulse |
| rx_eop | output | 1 | Single-cycle pulse on a clean end of packet |

## Verification
The bench targets stuffing at its boundaries:
- Runs of 0xFF bytes force a stuffed zero that starts counting from the sync field's own final one. A design that forgot that seed would leave the stuffed zero in the data and corrupt the byte.
- A seventh one without a stuffed zero must raise an error. The bench then sends a complete sync field before the line returns to idle. A receiver that re-armed too early would open a phantom packet.

The bench also covers the framing edges:
- A truncated sync field must not open a packet.
- A lone SE0 inside a packet must count as an error.
- A packet ending mid-byte must not leak a short byte.
- Line activity while `bit_en` is low must be ignored. A design that clocked without the strobe would deliver garbled bytes.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

   // Line state as {dp, dm}
   typedef enum logic [1:0] {
      LINE_SE0 = 2'b00,
      LINE_K   = 2'b01,
      LINE_J   = 2'b10,
      LINE_SE1 = 2'b11
   } line_t;

   typedef enum logic [1:0] {
      RX_HUNT   = 2'd0,
      RX_PACKET = 2'd1,
      RX_DEAF   = 2'd2
   } rx_state_t;

   // Number of consecutive ones at the tail (last received end) of a pattern
   function automatic int tail_ones(input logic [31:0] pat, input int width);
      int n;
      n = 0;
      for (int i = 0; i < width; i++) begin
         if (pat[i] && (n == i)) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/usbrx_nrzi.sv
module usbrx_nrzi
   import usbrx_pkg::*;
#(
   parameter bit CHANGE_IS_ONE = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  bit_en,
   input  logic  line_dp,
   input  logic  line_dm,
   output line_t line_st,
   output logic  dec_bit
);

   logic prev_lvl_q;
   logic same_lvl;

   assign line_st  = line_t'({line_dp, line_dm});
   assign same_lvl = (line_dp == prev_lvl_q);

   generate
      if (CHANGE_IS_ONE) begin : g_change_one
         assign dec_bit = ~same_lvl;
      end else begin : g_change_zero
         assign dec_bit = same_lvl;
      end
   endgenerate

   // Level history skips SE0 samples so the first bit after EOP decodes against J
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl_q <= 1'b1;
      end else if (bit_en && (line_st != LINE_SE0)) begin
         prev_lvl_q <= line_dp;
      end
   end

endmodule

// File: rtl/usbrx_unstuff.sv
module usbrx_unstuff #(
   parameter int STUFF_LIMIT = 6,
   parameter int START_ONES  = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic data_bit,
   input  logic dec_bit,
   output logic keep_bit,
   output logic stuff_err
);

   localparam int CNT_W = $clog2(STUFF_LIMIT + 1);

   generate
      if (STUFF_LIMIT < 1) begin : g_bad_limit
         $error("usbrx_unstuff: STUFF_LIMIT must be at least 1");
      end
      if (START_ONES > STUFF_LIMIT) begin : g_bad_start
         $error("usbrx_unstuff: sync tail longer than stuffing limit");
      end
   endgenerate

   logic [CNT_W-1:0] ones_q;
   logic             at_limit;

   assign at_limit  = (ones_q == CNT_W'(STUFF_LIMIT));
   assign keep_bit  = data_bit && !at_limit;
   assign stuff_err = data_bit && at_limit && dec_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
      end else if (start) begin
         ones_q <= CNT_W'(START_ONES);
      end else if (data_bit) begin
         if (at_limit || !dec_bit) ones_q <= '0;
         else                      ones_q <= ones_q + 1'b1;
      end
   end

endmodule

// File: rtl/usbrx_deser.sv
module usbrx_deser #(
   parameter int DATA_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [DATA_W-1:0] hold_q,
   output logic              valid_q
);

   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("usbrx_deser: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] shift_q;
   logic [DATA_W-1:0] shift_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              last_bit;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign shift_nxt = {bit_in, shift_q[DATA_W-1:1]};
      end else begin : g_msb
         assign shift_nxt = {shift_q[DATA_W-2:0], bit_in};
      end
   endgenerate

   assign last_bit = (cnt_q == CNT_W'(DATA_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         cnt_q   <= '0;
         hold_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (clear) begin
            cnt_q <= '0;
         end else if (shift_en) begin
            shift_q <= shift_nxt;
            if (last_bit) begin
               cnt_q   <= '0;
               hold_q  <= shift_nxt;
               valid_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/usbrx_top.sv
module usbrx_top
   import usbrx_pkg::*;
#(
   parameter int              DATA_W        = 8,
   parameter int              STUFF_LIMIT   = 6,
   parameter int              SYNC_W        = 8,
   parameter logic [SYNC_W-1:0] SYNC_PATTERN = 8'b0000_0001,
   parameter int              EOP_SE0_BITS  = 2,
   parameter bit              LSB_FIRST     = 1'b1,
   parameter bit              CHANGE_IS_ONE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              line_dp,
   input  logic              line_dm,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_active,
   output logic              rx_error,
   output logic              rx_eop
);

   localparam int SE0_W      = $clog2(EOP_SE0_BITS + 1);
   localparam int SYNC_TAIL  = tail_ones(32'(SYNC_PATTERN), SYNC_W);

   generate
      if (SYNC_W < 2 || SYNC_W > 32) begin : g_bad_sync
         $error("usbrx_top: SYNC_W out of range");
      end
      if (EOP_SE0_BITS < 1) begin : g_bad_eop
         $error("usbrx_top: EOP_SE0_BITS must be at least 1");
      end
   endgenerate

   line_t            line_st;
   logic             dec_bit;
   rx_state_t        state_q;
   logic [SE0_W-1:0] se0_q;
   logic [SYNC_W-1:0] hist_q;
   logic [SYNC_W-1:0] hist_nxt;
   logic             is_se0;
   logic             is_j;
   logic             sync_hit;
   logic             data_bit;
   logic             keep_bit;
   logic             stuff_err;
   logic             eop_done;
   logic             eop_bad;
   logic             err_now;
   logic             err_q;
   logic             eop_q;

   usbrx_nrzi #(
      .CHANGE_IS_ONE(CHANGE_IS_ONE)
   ) u_nrzi (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (bit_en),
      .line_dp (line_dp),
      .line_dm (line_dm),
      .line_st (line_st),
      .dec_bit (dec_bit)
   );

   assign is_se0   = (line_st == LINE_SE0);
   assign is_j     = (line_st == LINE_J);
   assign hist_nxt = {hist_q[SYNC_W-2:0], dec_bit};
   assign sync_hit = bit_en && (state_q == RX_HUNT) && !is_se0 && (hist_nxt == SYNC_PATTERN);

   // Data bits only while no SE0 run is in progress
   assign data_bit = bit_en && (state_q == RX_PACKET) && !is_se0 && (se0_q == '0);

   assign eop_done = bit_en && (state_q == RX_PACKET) && is_j &&
                     (se0_q == SE0_W'(EOP_SE0_BITS));
   assign eop_bad  = bit_en && (state_q == RX_PACKET) &&
                     ((is_se0 && (se0_q == SE0_W'(EOP_SE0_BITS))) ||
                      (!is_se0 && (se0_q != '0) && !eop_done));
   assign err_now  = stuff_err || eop_bad;

   usbrx_unstuff #(
      .STUFF_LIMIT (STUFF_LIMIT),
      .START_ONES  (SYNC_TAIL)
   ) u_unstuff (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (sync_hit),
      .data_bit  (data_bit),
      .dec_bit   (dec_bit),
      .keep_bit  (keep_bit),
      .stuff_err (stuff_err)
   );

   usbrx_deser #(
      .DATA_W    (DATA_W),
      .LSB_FIRST (LSB_FIRST)
   ) u_deser (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (sync_hit),
      .shift_en (keep_bit && !err_now),
      .bit_in   (dec_bit),
      .hold_q   (rx_data),
      .valid_q  (rx_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_HUNT;
         se0_q   <= '0;
         hist_q  <= '1;
         err_q   <= 1'b0;
         eop_q   <= 1'b0;
      end else begin
         err_q <= 1'b0;
         eop_q <= 1'b0;
         if (bit_en) begin
            unique case (state_q)
               RX_HUNT: begin
                  se0_q <= '0;
                  if (sync_hit || is_se0) hist_q <= '1;
                  else                    hist_q <= hist_nxt;
                  if (sync_hit) state_q <= RX_PACKET;
               end
               RX_PACKET: begin
                  hist_q <= '1;
                  if (err_now) begin
                     state_q <= RX_DEAF;
                     se0_q   <= is_se0 ? SE0_W'(1) : '0;
                     err_q   <= 1'b1;
                  end else if (eop_done) begin
                     state_q <= RX_HUNT;
                     se0_q   <= '0;
                     eop_q   <= 1'b1;
                  end else if (is_se0) begin
                     se0_q <= se0_q + 1'b1;
                  end
               end
               RX_DEAF: begin
                  hist_q <= '1;
                  if (is_se0) begin
                     se0_q <= SE0_W'(1);
                  end else if (is_j && (se0_q != '0)) begin
                     state_q <= RX_HUNT;
                     se0_q   <= '0;
                  end else begin
                     se0_q <= '0;
                  end
               end
               default: begin
                  state_q <= RX_HUNT;
                  se0_q   <= '0;
               end
            endcase
         end
      end
   end

   assign rx_active = (state_q == RX_PACKET);
   assign rx_error  = err_q;
   assign rx_eop    = eop_q;

endmodule

// File: rtl/usbrx_checker.sv
module usbrx_checker (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic rx_valid,
   input logic rx_active,
   input logic rx_error,
   input logic rx_eop
);

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);                                   // R3

   AST_VALID_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> rx_active);                                   // R3

   AST_ERROR_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_error |-> (!rx_active && $past(rx_active)));            // R5

   AST_ERROR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_error |=> !rx_error);                                   // R5

   AST_EOP_ENDS_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
      rx_eop |-> (!rx_active && $past(rx_active)));              // R7

   AST_EOP_NOT_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_eop && rx_error));                                    // R7

   AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(rx_active));                           // R10

   AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(bit_en));                               // R10

endmodule

bind usbrx_top usbrx_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_en    (bit_en),
   .rx_valid  (rx_valid),
   .rx_active (rx_active),
   .rx_error  (rx_error),
   .rx_eop    (rx_eop)
);

// File: tb/usbrx_top_test.sv
module usbrx_top_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       line_dp = 1'b1;
   logic       line_dm = 1'b0;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       rx_active;
   logic       rx_error;
   logic       rx_eop;

   int n_cmp = 0;
   int n_bad = 0;

   // Monitor state
   logic [7:0] got [0:15];
   int got_n = 0;
   int err_n = 0;
   int eop_n = 0;

   // Line encoder state
   logic lvl  = 1'b1;
   int   ones = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usbrx_top uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .line_dp   (line_dp),
      .line_dm   (line_dm),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid),
      .rx_active (rx_active),
      .rx_error  (rx_error),
      .rx_eop    (rx_eop)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin
            if (got_n < 16) got[got_n] = rx_data;
            got_n = got_n + 1;
         end
         if (rx_error) err_n = err_n + 1;
         if (rx_eop)   eop_n = eop_n + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      got_n = 0;
      err_n = 0;
      eop_n = 0;
   endtask

   task automatic put_line(input logic dp, input logic dm);
      @(negedge clk);
      line_dp = dp;
      line_dm = dm;
      bit_en  = 1'b1;
      @(negedge clk);
      bit_en  = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_raw(input logic b);
      if (!b) lvl = ~lvl;
      put_line(lvl, ~lvl);
   endtask

   task automatic send_idle(input int n);
      for (int i = 0; i < n; i++) put_line(1'b1, 1'b0);
      lvl = 1'b1;
   endtask

   task automatic send_sync();
      for (int i = 0; i < 7; i++) send_raw(1'b0);
      send_raw(1'b1);
      ones = 1;
   endtask

   task automatic send_bit(input logic b);
      send_raw(b);
      ones = b ? ones + 1 : 0;
      if (ones == 6) begin
         send_raw(1'b0);
         ones = 0;
      end
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) send_bit(v[i]);
   endtask

   task automatic send_eop();
      put_line(1'b0, 1'b0);
      put_line(1'b0, 1'b0);
      put_line(1'b1, 1'b0);
      lvl = 1'b1;
   endtask

   // R9
   task automatic t_reset();
      check("R9 rx_active after reset", rx_active, 0);
      check("R9 rx_valid after reset", rx_valid, 0);
      check("R9 rx_error after reset", rx_error, 0);
      check("R9 rx_eop after reset", rx_eop, 0);
   endtask

   // R1 R2 R3 R7
   task automatic t_basic();
      clear_mon();
      send_idle(3);
      send_sync();
      check("R2 rx_active after sync", rx_active, 1);
      send_byte(8'hA5);
      send_byte(8'h3C);
      send_byte(8'h00);
      check("R7 active before eop", rx_active, 1);
      send_eop();
      check("R7 rx_active after eop", rx_active, 0);
      check("R7 eop pulses", eop_n, 1);
      check("R3 byte count", got_n, 3);
      check("R3 R1 byte0", got[0], 8'hA5);
      check("R3 R1 byte1", got[1], 8'h3C);
      check("R3 R1 byte2", got[2], 8'h00);
      check("R5 no error in clean packet", err_n, 0);
   endtask

   // R4
   task automatic t_stuff();
      clear_mon();
      send_idle(2);
      send_sync();
      send_byte(8'hFF);
      send_byte(8'hFF);
      send_byte(8'h7E);
      send_eop();
      check("R4 byte count", got_n, 3);
      check("R4 ff0", got[0], 8'hFF);
      check("R4 ff1", got[1], 8'hFF);
      check("R4 7e", got[2], 8'h7E);
      check("R4 no error", err_n, 0);
   endtask

   // R5 R6
   task automatic t_stuff_error();
      clear_mon();
      send_idle(2);
      send_sync();
      for (int i = 0; i < 6; i++) send_raw(1'b1);
      check("R5 error pulse", err_n, 1);
      check("R5 active dropped", rx_active, 0);
      lvl = 1'b1;
      send_byte(8'hA5);
      send_sync();
      check("R6 sync ignored while deaf", rx_active, 0);
      send_byte(8'h11);
      send_eop();
      check("R5 no bytes after error", got_n, 0);
      check("R6 no eop while deaf", eop_n, 0);
      send_idle(2);
      send_sync();
      check("R6 rearmed after idle", rx_active, 1);
      send_byte(8'h5A);
      send_eop();
      check("R6 byte after rearm", got_n, 1);
      check("R6 rearm byte value", got[0], 8'h5A);
   endtask

   // R2 negative
   task automatic t_noise();
      clear_mon();
      send_idle(2);
      for (int i = 0; i < 6; i++) send_raw(1'b0);
      send_raw(1'b1);
      check("R2 short sync ignored", rx_active, 0);
      send_raw(1'b0);
      send_raw(1'b1);
      send_raw(1'b0);
      send_raw(1'b1);
      check("R2 noise no packet", rx_active, 0);
      send_idle(3);
      check("R2 noise no bytes", got_n, 0);
   endtask

   // R8
   task automatic t_partial();
      clear_mon();
      send_idle(2);
      send_sync();
      send_byte(8'h12);
      send_bit(1'b1);
      send_bit(1'b0);
      send_bit(1'b1);
      send_bit(1'b1);
      send_bit(1'b0);
      send_eop();
      check("R8 only full bytes", got_n, 1);
      check("R8 full byte value", got[0], 8'h12);
      check("R8 eop seen", eop_n, 1);
   endtask

   // R7 malformed SE0 run
   task automatic t_short_se0();
      clear_mon();
      send_idle(2);
      send_sync();
      send_byte(8'h44);
      put_line(1'b0, 1'b0);
      put_line(1'b0, 1'b1);
      check("R7 lone SE0 is error", err_n, 1);
      check("R7 lone SE0 drops active", rx_active, 0);
      check("R7 lone SE0 no eop", eop_n, 0);
      send_eop();
      send_idle(2);
   endtask

   // R10
   task automatic t_gating();
      clear_mon();
      send_idle(2);
      send_sync();
      send_bit(1'b1);
      send_bit(1'b0);
      send_bit(1'b0);
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         line_dp = i[0];
         line_dm = i[1];
      end
      check("R10 active held without strobe", rx_active, 1);
      check("R10 no byte without strobe", got_n, 0);
      send_bit(1'b1);
      send_bit(1'b0);
      send_bit(1'b1);
      send_bit(1'b1);
      send_bit(1'b0);
      send_eop();
      check("R10 byte intact", got[0], 8'h69);
      check("R10 one byte", got_n, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_basic();
      t_stuff();
      t_stuff_error();
      t_noise();
      t_partial();
      t_short_se0();
      t_gating();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule